// File: doc/BRIEF.md
# Application Power-Mode Controller

This block sequences the power state of an application processor domain. It has five states: active, sleep, deep sleep with partial retention, hibernate and shutdown. Software asks to enter one of the three low-power states that it may select. A filter then admits only the wake events allowed in that state: a fast timer pulse, a real-time-clock expiry pulse, GPIO lines and peripheral activity. The level of an active-low reset pin alone enters and leaves shutdown, and that pin overrides every other input.

For each state the controller drives registered enables: a clock gate, a main power gate and an always-on enable. It also drives a retention mask that selects which memory banks keep their contents during deep sleep. After a wake, a down-counter loaded with the exit latency of the state being left holds the `ready` flag low. Each latency is a parameter given in clock cycles. If an entry request arrives while that count is still running, the controller holds it and carries it out once `ready` is high.

Top module: `app_pwr_ctrl`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the state is active (code 0), `ready`, `clk_en`, `pwr_en` and `aon_en` are 1 and `ret_mask` is 0.
- R2: When active and ready, a `req_valid` pulse enters a new state on the next edge. `req_mode` 0 selects sleep, 1 deep sleep and 2 hibernate, and 3 is ignored. `state_o` codes are 0 active, 1 sleep, 2 deep sleep, 3 hibernate and 4 shutdown.
- R3: The enables {`clk_en`,`pwr_en`,`aon_en`} are 111 in active, 011 in sleep, 001 in deep sleep, 001 in hibernate and 000 in shutdown.
- R4: Sleep is left on the edge where `wk_fast_tmr`, any bit of `wk_gpio` or `wk_periph` is high. `ready` is already 1 after that same edge (default latency 0).
- R5: Deep sleep is left on `wk_rtc` or on a `wk_gpio` bit that was set in `req_gpio_sel` at entry. `ready` rises LAT_LPDS edges after the edge that returns to active.
- R6: Hibernate is left on `wk_rtc` or on any `wk_gpio` bit. `ready` rises LAT_HIB edges after the return to active.
- R7: A wake source that is not enabled in the current state leaves that state unchanged: `wk_rtc` in sleep, `wk_fast_tmr` and `wk_periph` in deep sleep and hibernate, and unselected GPIO bits in deep sleep.
- R8: `rst_pin_n` low forces shutdown on the next edge from any state and keeps it there. Once the pin is high again, the controller returns to active on the next edge, and `ready` rises LAT_SHUT edges later.
- R9: Entering deep sleep loads `ret_mask` from `req_ret_mask`, and the mask stays unchanged after waking from deep sleep. Entering hibernate or shutdown clears `ret_mask` to 0.
- R10: A request accepted while `ready` is 0 in active is held and carried out on the edge after `ready` rises.
- R11: Requests made in any state other than active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_n | input | 1 | Reset pin level, low means shutdown |
| req_valid | input | 1 | Entry request strobe |
| req_mode | input | 2 | Requested state (0 sleep, 1 deep sleep, 2 hibernate) |
| req_ret_mask | input | NBANK | Banks to retain in deep sleep |
| req_gpio_sel | input | NGPIO | GPIO lines allowed to wake from deep sleep |
| wk_fast_tmr | input | 1 | Fast timer wake pulse |
| wk_rtc | input | 1 | RTC expiry wake pulse |
| wk_gpio | input | NGPIO | GPIO wake events |
| wk_periph | input | 1 | Peripheral activity wake |
| state_o | output | 3 | Current state code |
| ready | output | 1 | Active with wake latency elapsed |
| clk_en | output | 1 | Domain clock enable |
| pwr_en | output | 1 | Domain logic power enable |
| aon_en | output | 1 | Always-on section (RTC) enable |
| ret_mask | output | NBANK | Memory bank retention mask |

## Verification
On every cycle, the assertions check these rules: the pin override into shutdown, the enable pattern of shutdown and hibernate, `ready` only in active, the one-edge return from sleep on the fast timer, the mask held through a deep-sleep wake, and hibernate ignoring timer and peripheral events. Only the bench's scenarios can show the exact latency of each exit path, a held request carried out after the count, and the GPIO selection captured at deep-sleep entry. The same applies to requests ignored in sleep and shutdown and to the unused mode code.

// File: rtl/apm_pkg.sv
package apm_pkg;

  typedef enum logic [2:0] {
    PM_ACTIVE = 3'd0,
    PM_SLEEP  = 3'd1,
    PM_LPDS   = 3'd2,
    PM_HIB    = 3'd3,
    PM_SHUT   = 3'd4
  } pm_state_e;

  typedef enum logic [1:0] {
    REQ_SLEEP = 2'd0,
    REQ_LPDS  = 2'd1,
    REQ_HIB   = 2'd2,
    REQ_NONE  = 2'd3
  } pm_req_e;

  typedef struct packed {
    logic clk_en;
    logic pwr_en;
    logic aon_en;
  } pm_gate_t;

  function automatic pm_gate_t gate_of(pm_state_e s);
    pm_gate_t g;
    case (s)
      PM_ACTIVE: g = '{clk_en: 1'b1, pwr_en: 1'b1, aon_en: 1'b1};
      PM_SLEEP:  g = '{clk_en: 1'b0, pwr_en: 1'b1, aon_en: 1'b1};
      PM_LPDS:   g = '{clk_en: 1'b0, pwr_en: 1'b0, aon_en: 1'b1};
      PM_HIB:    g = '{clk_en: 1'b0, pwr_en: 1'b0, aon_en: 1'b1};
      default:   g = '{clk_en: 1'b0, pwr_en: 1'b0, aon_en: 1'b0};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/apm_wake_sel.sv
module apm_wake_sel
  import apm_pkg::*;
#(
  parameter int NGPIO = 4
) (
  input  pm_state_e        st,
  input  logic [NGPIO-1:0] gpio_sel,
  input  logic             wk_fast,
  input  logic             wk_rtc,
  input  logic [NGPIO-1:0] wk_gpio,
  input  logic             wk_periph,
  output logic             wake
);

  logic any_gpio;
  logic sel_gpio;

  assign any_gpio = |wk_gpio;
  assign sel_gpio = |(wk_gpio & gpio_sel);

  always_comb begin
    case (st)
      PM_SLEEP: wake = wk_fast | any_gpio | wk_periph;
      PM_LPDS:  wake = wk_rtc | sel_gpio;
      PM_HIB:   wake = wk_rtc | any_gpio;
      default:  wake = 1'b0;
    endcase
  end

endmodule

// File: rtl/apm_lat_ctr.sv
module apm_lat_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero_next
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign zero_next = load ? (load_val == '0) : (cnt <= CW'(1));

endmodule

// File: rtl/app_pwr_ctrl.sv
module app_pwr_ctrl
  import apm_pkg::*;
#(
  parameter int NGPIO     = 4,
  parameter int NBANK     = 4,
  parameter int LAT_SLEEP = 0,
  parameter int LAT_LPDS  = 5,
  parameter int LAT_HIB   = 9,
  parameter int LAT_SHUT  = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_pin_n,
  input  logic             req_valid,
  input  logic [1:0]       req_mode,
  input  logic [NBANK-1:0] req_ret_mask,
  input  logic [NGPIO-1:0] req_gpio_sel,
  input  logic             wk_fast_tmr,
  input  logic             wk_rtc,
  input  logic [NGPIO-1:0] wk_gpio,
  input  logic             wk_periph,
  output logic [2:0]       state_o,
  output logic             ready,
  output logic             clk_en,
  output logic             pwr_en,
  output logic             aon_en,
  output logic [NBANK-1:0] ret_mask
);

  localparam int LAT_M1  = (LAT_SLEEP > LAT_LPDS) ? LAT_SLEEP : LAT_LPDS;
  localparam int LAT_M2  = (LAT_HIB > LAT_SHUT) ? LAT_HIB : LAT_SHUT;
  localparam int LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
  localparam int CW      = (LAT_MAX < 1) ? 1 : $clog2(LAT_MAX + 1);

  pm_state_e        st, st_n;
  pm_gate_t         gate_q;
  logic             ready_q;
  logic [NBANK-1:0] mask_q, mask_n;
  logic [NGPIO-1:0] sel_q, sel_n;

  logic             pend_vld, pend_vld_n;
  logic [1:0]       pend_mode, pend_mode_n;
  logic [NBANK-1:0] pend_mask, pend_mask_n;
  logic [NGPIO-1:0] pend_sel, pend_sel_n;

  logic             eff_vld;
  logic [1:0]       eff_mode;
  logic [NBANK-1:0] eff_mask;
  logic [NGPIO-1:0] eff_sel;

  logic             wake;
  logic             ld;
  logic [CW-1:0]    ld_val;
  logic             zero_next;

  assign eff_vld  = req_valid | pend_vld;
  assign eff_mode = req_valid ? req_mode     : pend_mode;
  assign eff_mask = req_valid ? req_ret_mask : pend_mask;
  assign eff_sel  = req_valid ? req_gpio_sel : pend_sel;

  apm_wake_sel #(.NGPIO(NGPIO)) u_wake (
    .st        (st),
    .gpio_sel  (sel_q),
    .wk_fast   (wk_fast_tmr),
    .wk_rtc    (wk_rtc),
    .wk_gpio   (wk_gpio),
    .wk_periph (wk_periph),
    .wake      (wake)
  );

  apm_lat_ctr #(.CW(CW)) u_lat (
    .clk       (clk),
    .rst       (rst),
    .load      (ld),
    .load_val  (ld_val),
    .zero_next (zero_next)
  );

  always_comb begin
    st_n        = st;
    ld          = 1'b0;
    ld_val      = '0;
    mask_n      = mask_q;
    sel_n       = sel_q;
    pend_vld_n  = pend_vld;
    pend_mode_n = pend_mode;
    pend_mask_n = pend_mask;
    pend_sel_n  = pend_sel;
    if (!rst_pin_n) begin
      st_n       = PM_SHUT;
      ld         = 1'b1;
      mask_n     = '0;
      pend_vld_n = 1'b0;
    end else begin
      case (st)
        PM_ACTIVE: begin
          if (!ready_q) begin
            if (req_valid) begin
              pend_vld_n  = 1'b1;
              pend_mode_n = req_mode;
              pend_mask_n = req_ret_mask;
              pend_sel_n  = req_gpio_sel;
            end
          end else if (eff_vld) begin
            pend_vld_n = 1'b0;
            case (pm_req_e'(eff_mode))
              REQ_SLEEP: st_n = PM_SLEEP;
              REQ_LPDS: begin
                st_n   = PM_LPDS;
                mask_n = eff_mask;
                sel_n  = eff_sel;
              end
              REQ_HIB: begin
                st_n   = PM_HIB;
                mask_n = '0;
              end
              default: st_n = PM_ACTIVE;
            endcase
          end
        end
        PM_SLEEP: if (wake) begin
          st_n = PM_ACTIVE; ld = 1'b1; ld_val = CW'(LAT_SLEEP);
        end
        PM_LPDS: if (wake) begin
          st_n = PM_ACTIVE; ld = 1'b1; ld_val = CW'(LAT_LPDS);
        end
        PM_HIB: if (wake) begin
          st_n = PM_ACTIVE; ld = 1'b1; ld_val = CW'(LAT_HIB);
        end
        PM_SHUT: begin
          st_n = PM_ACTIVE; ld = 1'b1; ld_val = CW'(LAT_SHUT);
        end
        default: st_n = PM_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PM_ACTIVE;
      gate_q    <= gate_of(PM_ACTIVE);
      ready_q   <= 1'b1;
      mask_q    <= '0;
      sel_q     <= '0;
      pend_vld  <= 1'b0;
      pend_mode <= '0;
      pend_mask <= '0;
      pend_sel  <= '0;
    end else begin
      st        <= st_n;
      gate_q    <= gate_of(st_n);
      ready_q   <= (st_n == PM_ACTIVE) && zero_next;
      mask_q    <= mask_n;
      sel_q     <= sel_n;
      pend_vld  <= pend_vld_n;
      pend_mode <= pend_mode_n;
      pend_mask <= pend_mask_n;
      pend_sel  <= pend_sel_n;
    end
  end

  assign state_o  = st;
  assign ready    = ready_q;
  assign clk_en   = gate_q.clk_en;
  assign pwr_en   = gate_q.pwr_en;
  assign aon_en   = gate_q.aon_en;
  assign ret_mask = mask_q;

endmodule

// File: rtl/apm_checker.sv
module apm_checker #(
  parameter int NGPIO = 4,
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rst_pin_n,
  input logic             wk_fast_tmr,
  input logic             wk_rtc,
  input logic             wk_periph,
  input logic [NGPIO-1:0] wk_gpio,
  input logic [2:0]       state_o,
  input logic             ready,
  input logic             clk_en,
  input logic             pwr_en,
  input logic             aon_en,
  input logic [NBANK-1:0] ret_mask
);

  localparam logic [2:0] S_ACT = 3'd0;
  localparam logic [2:0] S_SLP = 3'd1;
  localparam logic [2:0] S_LPD = 3'd2;
  localparam logic [2:0] S_HIB = 3'd3;
  localparam logic [2:0] S_SHT = 3'd4;

  AST_PIN_FORCES_SHUT: assert property (@(posedge clk) disable iff (rst)
    !rst_pin_n |=> state_o == S_SHT); // R8

  AST_SHUT_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    state_o == S_SHT |-> !clk_en && !pwr_en && !aon_en && !ready); // R3

  AST_HIB_NO_RETAIN: assert property (@(posedge clk) disable iff (rst)
    state_o == S_HIB |-> ret_mask == '0 && !pwr_en && aon_en); // R9

  AST_READY_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    ready |-> state_o == S_ACT && clk_en && pwr_en); // R2

  AST_SLEEP_FAST_WAKE: assert property (@(posedge clk) disable iff (rst)
    state_o == S_SLP && rst_pin_n && wk_fast_tmr |=> ready); // R4

  AST_LPDS_MASK_KEPT: assert property (@(posedge clk) disable iff (rst)
    state_o == S_LPD && rst_pin_n |=> $stable(ret_mask)); // R9

  AST_HIB_IGNORES_OTHERS: assert property (@(posedge clk) disable iff (rst)
    state_o == S_HIB && rst_pin_n && !wk_rtc && !(|wk_gpio) && (wk_fast_tmr || wk_periph)
    |=> state_o == S_HIB); // R7

endmodule

bind app_pwr_ctrl apm_checker #(.NGPIO(NGPIO), .NBANK(NBANK)) u_apm_chk (
  .clk         (clk),
  .rst         (rst),
  .rst_pin_n   (rst_pin_n),
  .wk_fast_tmr (wk_fast_tmr),
  .wk_rtc      (wk_rtc),
  .wk_periph   (wk_periph),
  .wk_gpio     (wk_gpio),
  .state_o     (state_o),
  .ready       (ready),
  .clk_en      (clk_en),
  .pwr_en      (pwr_en),
  .aon_en      (aon_en),
  .ret_mask    (ret_mask)
);

// File: tb/app_pwr_ctrl_test.sv
module app_pwr_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int L_LPDS = 5;
  localparam int L_HIB  = 9;
  localparam int L_SHUT = 14;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_pin_n = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [3:0] req_ret_mask = 4'd0;
  logic [3:0] req_gpio_sel = 4'd0;
  logic       wk_fast_tmr = 1'b0;
  logic       wk_rtc = 1'b0;
  logic [3:0] wk_gpio = 4'd0;
  logic       wk_periph = 1'b0;
  logic [2:0] state_o;
  logic       ready, clk_en, pwr_en, aon_en;
  logic [3:0] ret_mask;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  app_pwr_ctrl #(.NGPIO(4), .NBANK(4), .LAT_SLEEP(0), .LAT_LPDS(L_LPDS),
                 .LAT_HIB(L_HIB), .LAT_SHUT(L_SHUT)) uut (
    .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .req_valid(req_valid),
    .req_mode(req_mode), .req_ret_mask(req_ret_mask), .req_gpio_sel(req_gpio_sel),
    .wk_fast_tmr(wk_fast_tmr), .wk_rtc(wk_rtc), .wk_gpio(wk_gpio), .wk_periph(wk_periph),
    .state_o(state_o), .ready(ready), .clk_en(clk_en), .pwr_en(pwr_en),
    .aon_en(aon_en), .ret_mask(ret_mask)
  );

  typedef struct {
    string    tag;
    int       st;
    bit       rdy;
    bit [3:0] mask;
  } exp_t;

  exp_t sb_q[$];

  function automatic bit [2:0] gates(int st);
    case (st)
      0: return 3'b111;
      1: return 3'b011;
      2: return 3'b001;
      3: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  // monitor: compares one expected item per cycle at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      exp_t e;
      bit [2:0] g;
      e = sb_q.pop_front();
      g = gates(e.st);
      checks++;
      if (state_o != 3'(e.st) || ready != e.rdy || {clk_en, pwr_en, aon_en} != g ||
          ret_mask != e.mask) begin
        failures++;
        $display("FAIL %s: got st=%0d rdy=%0b gates=%03b mask=%04b exp st=%0d rdy=%0b gates=%03b mask=%04b",
                 e.tag, state_o, ready, {clk_en, pwr_en, aon_en}, ret_mask,
                 e.st, e.rdy, g, e.mask);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string tag, int st, bit rdy, bit [3:0] mask);
    exp_t e;
    e.tag = tag; e.st = st; e.rdy = rdy; e.mask = mask;
    sb_q.push_back(e);
  endtask

  task automatic request(bit [1:0] mode, bit [3:0] m, bit [3:0] s);
    req_valid = 1'b1; req_mode = mode; req_ret_mask = m; req_gpio_sel = s;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic fire(bit ft, bit rtc, bit [3:0] g, bit per);
    wk_fast_tmr = ft; wk_rtc = rtc; wk_gpio = g; wk_periph = per;
    tick();
    wk_fast_tmr = 1'b0; wk_rtc = 1'b0; wk_gpio = 4'd0; wk_periph = 1'b0;
  endtask

  // after the wake edge: ready low until the L-th edge, then high
  task automatic wait_ready(string tag, int lat, bit [3:0] mask);
    for (int j = 1; j <= lat; j++) begin
      tick();
      expect_out(tag, 0, (j == lat), mask);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    expect_out("R1 reset state", 0, 1, 4'b0000);
    rst = 1'b0;
    tick();
    expect_out("R1 after release", 0, 1, 4'b0000);

    // sleep entry and wakes
    request(2'd0, 4'd0, 4'd0);
    expect_out("R2 R3 enter sleep", 1, 0, 4'b0000);
    fire(0, 1, 4'd0, 0);
    expect_out("R7 rtc ignored in sleep", 1, 0, 4'b0000);
    fire(1, 0, 4'd0, 0);
    expect_out("R4 fast timer wake instant", 0, 1, 4'b0000);
    request(2'd0, 4'd0, 4'd0);
    expect_out("R2 sleep again", 1, 0, 4'b0000);
    fire(0, 0, 4'b0100, 0);
    expect_out("R4 gpio wake from sleep", 0, 1, 4'b0000);
    request(2'd0, 4'd0, 4'd0);
    expect_out("R2 sleep third", 1, 0, 4'b0000);
    request(2'd1, 4'b1111, 4'd0);
    expect_out("R11 request in sleep ignored", 1, 0, 4'b0000);
    fire(0, 0, 4'd0, 1);
    expect_out("R4 peripheral wake", 0, 1, 4'b0000);

    request(2'd3, 4'b1111, 4'd0);
    expect_out("R2 mode 3 ignored", 0, 1, 4'b0000);

    // deep sleep with selected gpio
    request(2'd1, 4'b1010, 4'b0100);
    expect_out("R3 R9 enter deep sleep", 2, 0, 4'b1010);
    fire(0, 0, 4'b0001, 0);
    expect_out("R7 unselected gpio ignored", 2, 0, 4'b1010);
    fire(1, 0, 4'd0, 0);
    expect_out("R7 fast timer ignored in deep sleep", 2, 0, 4'b1010);
    fire(0, 0, 4'd0, 1);
    expect_out("R7 peripheral ignored in deep sleep", 2, 0, 4'b1010);
    fire(0, 0, 4'b0100, 0);
    expect_out("R5 R9 selected gpio wake", 0, 0, 4'b1010);
    // request during wake latency is held
    request(2'd0, 4'd0, 4'd0);
    expect_out("R10 request held while not ready", 0, 0, 4'b1010);
    for (int j = 2; j <= L_LPDS; j++) begin
      tick();
      expect_out("R5 deep sleep latency", 0, (j == L_LPDS), 4'b1010);
    end
    tick();
    expect_out("R10 held request taken", 1, 0, 4'b1010);
    fire(1, 0, 4'd0, 0);
    expect_out("R4 wake back", 0, 1, 4'b1010);

    // deep sleep, rtc wake
    request(2'd1, 4'b0011, 4'd0);
    expect_out("R9 new mask loaded", 2, 0, 4'b0011);
    fire(0, 1, 4'd0, 0);
    expect_out("R5 rtc wake", 0, 0, 4'b0011);
    wait_ready("R5 R9 latency mask kept", L_LPDS, 4'b0011);

    // hibernate
    request(2'd2, 4'b1111, 4'd0);
    expect_out("R3 R9 enter hibernate", 3, 0, 4'b0000);
    fire(1, 0, 4'd0, 1);
    expect_out("R7 hibernate ignores timer and peripheral", 3, 0, 4'b0000);
    fire(0, 0, 4'b1000, 0);
    expect_out("R6 gpio wake hibernate", 0, 0, 4'b0000);
    wait_ready("R6 hibernate latency", L_HIB, 4'b0000);
    request(2'd2, 4'd0, 4'd0);
    expect_out("R6 hibernate again", 3, 0, 4'b0000);
    fire(0, 1, 4'd0, 0);
    expect_out("R6 rtc wake hibernate", 0, 0, 4'b0000);
    wait_ready("R6 hibernate latency rtc", L_HIB, 4'b0000);

    // shutdown via pin
    rst_pin_n = 1'b0;
    tick();
    expect_out("R8 R3 pin low to shutdown", 4, 0, 4'b0000);
    request(2'd0, 4'd0, 4'd0);
    expect_out("R11 request in shutdown ignored", 4, 0, 4'b0000);
    fire(1, 1, 4'b1111, 1);
    expect_out("R8 stays in shutdown", 4, 0, 4'b0000);
    rst_pin_n = 1'b1;
    tick();
    expect_out("R8 leave shutdown", 0, 0, 4'b0000);
    wait_ready("R8 shutdown latency", L_SHUT, 4'b0000);

    // shutdown from deep sleep clears retention
    request(2'd1, 4'b1111, 4'b1111);
    expect_out("R9 deep sleep full mask", 2, 0, 4'b1111);
    rst_pin_n = 1'b0;
    tick();
    expect_out("R8 R9 shutdown clears mask", 4, 0, 4'b0000);
    rst_pin_n = 1'b1;
    tick();
    expect_out("R8 leave shutdown again", 0, 0, 4'b0000);
    wait_ready("R8 shutdown latency again", L_SHUT, 4'b0000);

    @(negedge clk);
    #1;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule